// File: doc/BRIEF.md
# Load/Store Address Generator

This unit works out the memory address for a word load or store. It also works out the new value for the base register. It takes a base register value and an offset. The offset is either a 12-bit unsigned immediate or a second register value that has passed through a shifter. The offset is added to or subtracted from the base. A two-bit indexing mode then chooses how the sum is used.

- **Plain offset mode:** the access goes to the sum and the base is left unchanged.
- **Pre-indexed mode:** the access goes to the sum and the sum is also written back to the base, like a pointer pre-increment.
- **Post-indexed mode:** the access goes to the original base and the sum is written back, like a pointer post-increment.

Stepping through an array of 32-bit words uses an immediate offset of 4.

All outputs are registered, so results appear one clock after the inputs are sampled. A word access whose address is not a multiple of four raises an alignment-fault flag. Memory access itself is not part of this unit; the downstream load/store path decides what to do with the flag and the writeback.

Top module: `ldst_agen`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first sampling edge, `addr_o`, `wb_data_o`, `wb_en_o` and `fault_o` are all zero.
- R2: With `mode_i` = 0 (plain offset): `addr_o` = base ± offset, `wb_data_o` = base unchanged, and `wb_en_o` = 0.
- R3: With `mode_i` = 1 (pre-indexed): `addr_o` = base ± offset, `wb_data_o` = `addr_o`, and `wb_en_o` = 1.
- R4: With `mode_i` = 2 (post-indexed): `addr_o` = base, `wb_data_o` = base ± offset, and `wb_en_o` = 1.
- R5: `mode_i` = 3 is reserved and behaves exactly like plain offset mode, with no writeback.
- R6: `up_i` = 1 adds the offset and `up_i` = 0 subtracts it. Both wrap modulo 2^32.
- R7: With `use_reg_i` = 0, the offset is `imm_i` zero-extended to 32 bits. For example, 0xFFF adds 4095.
- R8: With `use_reg_i` = 1, the offset is `rm_i` shifted by `shamt_i` (0..31). The shift type is set by `shtype_i`: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. An amount of 0 leaves `rm_i` unchanged for every type.
- R9: `fault_o` is 1 exactly when bits [1:0] of `addr_o` are not both zero.
- R10: Every output reflects the inputs sampled at the previous rising clock edge and not the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_i | input | 32 | Base register value |
| mode_i | input | 2 | Indexing mode: 0 offset, 1 pre-indexed, 2 post-indexed, 3 reserved |
| up_i | input | 1 | 1 adds the offset, 0 subtracts it |
| use_reg_i | input | 1 | 1 selects the shifted register offset, 0 selects the immediate |
| imm_i | input | 12 | Unsigned immediate offset |
| rm_i | input | 32 | Offset register value |
| shtype_i | input | 2 | Shift type: 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| shamt_i | input | 5 | Shift amount |
| addr_o | output | 32 | Effective address |
| wb_data_o | output | 32 | Value for the base register |
| wb_en_o | output | 1 | Base register writeback enable |
| fault_o | output | 1 | Word alignment fault |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath, a 12-bit immediate and a 5-bit shift amount. With these values, every shift amount for every shift type can be swept against several register patterns. The patterns include sign-bit-set values for the arithmetic shift and the rotate, in all four modes and both offset directions. The immediate boundaries 0, 4 and 0xFFF are applied together with base values near zero and near the top of the address space. This puts wraparound in both directions, the reserved mode and both alignment-fault outcomes within reach.

// File: rtl/ldst_agen.sv
module ldst_agen #(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 12,
  parameter int SHAMT_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  base_i,
  input  logic [1:0]         mode_i,
  input  logic               up_i,
  input  logic               use_reg_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [DATA_W-1:0]  rm_i,
  input  logic [1:0]         shtype_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [DATA_W-1:0]  addr_o,
  output logic [DATA_W-1:0]  wb_data_o,
  output logic               wb_en_o,
  output logic               fault_o
);

  localparam int ALIGN_W = 2;
  localparam logic [1:0] M_OFS  = 2'd0;
  localparam logic [1:0] M_PRE  = 2'd1;
  localparam logic [1:0] M_POST = 2'd2;

  logic [DATA_W-1:0]   shifted;
  logic [2*DATA_W-1:0] rot2;
  logic [DATA_W-1:0]   offset;
  logic [DATA_W-1:0]   sum;
  logic [DATA_W-1:0]   addr_d;
  logic [DATA_W-1:0]   wb_d;
  logic                wb_en_d;

  assign rot2 = {rm_i, rm_i} >> shamt_i;

  always_comb begin
    case (shtype_i)
      2'd0:    shifted = rm_i << shamt_i;
      2'd1:    shifted = rm_i >> shamt_i;
      2'd2:    shifted = DATA_W'($signed(rm_i) >>> shamt_i);
      default: shifted = rot2[DATA_W-1:0];
    endcase
  end

  assign offset  = use_reg_i ? shifted : {{(DATA_W-IMM_W){1'b0}}, imm_i};
  assign sum     = up_i ? base_i + offset : base_i - offset;
  assign wb_en_d = (mode_i == M_PRE) || (mode_i == M_POST);
  assign addr_d  = (mode_i == M_POST) ? base_i : sum;
  assign wb_d    = wb_en_d ? sum : base_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o    <= '0;
      wb_data_o <= '0;
      wb_en_o   <= 1'b0;
      fault_o   <= 1'b0;
    end else begin
      addr_o    <= addr_d;
      wb_data_o <= wb_d;
      wb_en_o   <= wb_en_d;
      fault_o   <= |addr_d[ALIGN_W-1:0];
    end
  end

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_fault_low_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o == (addr_o[ALIGN_W-1:0] != '0));

  assert_pre_updates_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mode_i) == M_PRE) |-> (wb_en_o && wb_data_o == addr_o));

  assert_post_uses_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mode_i) == M_POST) |-> (wb_en_o && addr_o == $past(base_i)));

  assert_offset_keeps_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ($past(mode_i) == M_OFS || $past(mode_i) == 2'd3))
      |-> (!wb_en_o && wb_data_o == $past(base_i)));

  assert_imm_add_sub_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mode_i) == M_POST && !$past(use_reg_i))
      |-> (wb_data_o == ($past(up_i)
             ? $past(base_i) + {{(DATA_W-IMM_W){1'b0}}, $past(imm_i)}
             : $past(base_i) - {{(DATA_W-IMM_W){1'b0}}, $past(imm_i)})));

endmodule

// File: tb/tb_ldst_agen.sv
module tb_ldst_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base_i = '0;
  logic [1:0]  mode_i = '0;
  logic        up_i = 1'b0;
  logic        use_reg_i = 1'b0;
  logic [11:0] imm_i = '0;
  logic [31:0] rm_i = '0;
  logic [1:0]  shtype_i = '0;
  logic [4:0]  shamt_i = '0;
  logic [31:0] addr_o, wb_data_o;
  logic        wb_en_o, fault_o;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ldst_agen dut (
    .clk(clk), .rst_n(rst_n), .base_i(base_i), .mode_i(mode_i), .up_i(up_i),
    .use_reg_i(use_reg_i), .imm_i(imm_i), .rm_i(rm_i), .shtype_i(shtype_i),
    .shamt_i(shamt_i), .addr_o(addr_o), .wb_data_o(wb_data_o),
    .wb_en_o(wb_en_o), .fault_o(fault_o)
  );

  function automatic logic [31:0] shift_ref(logic [31:0] v, logic [1:0] t, int n);
    logic [31:0] r;
    r = v;
    for (int i = 0; i < n; i++) begin
      case (t)
        2'd0: r = {r[30:0], 1'b0};
        2'd1: r = {1'b0, r[31:1]};
        2'd2: r = {r[31], r[31:1]};
        default: r = {r[0], r[31:1]};
      endcase
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (base=%h mode=%0d up=%0b reg=%0b imm=%h rm=%h t=%0d n=%0d)",
               req, act, exp, base_i, mode_i, up_i, use_reg_i, imm_i, rm_i, shtype_i, shamt_i);
    end
  endtask

  task automatic run_vec(logic [31:0] b, logic [1:0] m, logic u, logic r,
                         logic [11:0] im, logic [31:0] rm, logic [1:0] t, int n);
    logic [31:0] off, sum, ea, wb;
    logic en;
    string tag;
    @(negedge clk);
    base_i = b; mode_i = m; up_i = u; use_reg_i = r; imm_i = im;
    rm_i = rm; shtype_i = t; shamt_i = 5'(n);
    off = r ? shift_ref(rm, t, n) : {20'd0, im};
    sum = u ? b + off : b - off;
    en  = (m == 2'd1) || (m == 2'd2);
    ea  = (m == 2'd2) ? b : sum;
    wb  = en ? sum : b;
    tag = (m == 2'd0) ? "R2" : (m == 2'd1) ? "R3" : (m == 2'd2) ? "R4" : "R5";
    if (r) tag = {tag, "/R8"}; else tag = {tag, "/R7"};
    @(negedge clk);
    chk({tag, "/R6 addr"}, addr_o, ea);
    chk({tag, "/R6 wb_data"}, wb_data_o, wb);
    chk({tag, " wb_en"}, {31'd0, wb_en_o}, {31'd0, en});
    chk("R9 fault", {31'd0, fault_o}, {31'd0, ea[1:0] != 2'b00});
  endtask

  initial begin
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] bases [4];
    logic [11:0] imms [4];
    logic [31:0] rms [3];
    bases = '{32'h0000_0000, 32'h0000_1000, 32'hFFFF_FFFC, 32'h8000_0002};
    imms  = '{12'h000, 12'h004, 12'hFFF, 12'h001};
    rms   = '{32'h0000_0001, 32'h8000_0013, 32'hF0F0_A5A5};

    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 addr", addr_o, 32'd0);
    chk("R1 wb_data", wb_data_o, 32'd0);
    chk("R1 wb_en/fault", {30'd0, wb_en_o, fault_o}, 32'd0);
    base_i = 32'h1234_5677; mode_i = 2'd1; up_i = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 held after release", addr_o, 32'd0);

    // R10: output changes only after the next rising edge
    run_vec(32'h0000_0100, 2'd1, 1'b1, 1'b0, 12'h004, 32'd0, 2'd0, 0);
    base_i = 32'h0000_0F00; imm_i = 12'h008;
    #1;
    chk("R10 before edge", addr_o, 32'h0000_0104);
    @(negedge clk);
    chk("R10 after edge", addr_o, 32'h0000_0F08);

    // R6: wraparound both ways
    run_vec(32'hFFFF_FFFC, 2'd0, 1'b1, 1'b0, 12'h004, 32'd0, 2'd0, 0);
    chk("R6 wrap up", addr_o, 32'h0000_0000);
    run_vec(32'h0000_0000, 2'd0, 1'b0, 1'b0, 12'h004, 32'd0, 2'd0, 0);
    chk("R6 wrap down", addr_o, 32'hFFFF_FFFC);
    // R7: max immediate zero-extended
    run_vec(32'h0000_0000, 2'd2, 1'b1, 1'b0, 12'hFFF, 32'd0, 2'd0, 0);
    chk("R7 zero-extend", wb_data_o, 32'h0000_0FFF);
    // R8: ASR of negative by 31, ROR by 4
    run_vec(32'h0000_0000, 2'd0, 1'b1, 1'b1, 12'h0, 32'h8000_0000, 2'd2, 31);
    chk("R8 asr", addr_o, 32'hFFFF_FFFF);
    run_vec(32'h0000_0000, 2'd0, 1'b1, 1'b1, 12'h0, 32'h0000_0012, 2'd3, 4);
    chk("R8 ror", addr_o, 32'h2000_0001);

    // immediate sweep
    for (int b = 0; b < 4; b++)
      for (int m = 0; m < 4; m++)
        for (int u = 0; u < 2; u++)
          for (int i = 0; i < 4; i++)
            run_vec(bases[b], 2'(m), 1'(u), 1'b0, imms[i], 32'd0, 2'd0, 0);

    // register offset sweep
    for (int b = 0; b < 4; b++)
      for (int m = 0; m < 4; m++)
        for (int u = 0; u < 2; u++)
          for (int r = 0; r < 3; r++)
            for (int t = 0; t < 4; t++)
              for (int n = 0; n < 32; n++)
                run_vec(bases[b], 2'(m), 1'(u), 1'b1, 12'hABC, rms[r], 2'(t), n);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule